// File: doc/BRIEF.md
# External Bus Cycle and Byte-Enable Controller

This block runs single bus cycles on the external bus of a 32-bit embedded controller. The core presents a request with an address, an access size (byte, halfword or word), a direction, write data and the current bus width (8, 16 or 32 bits). The controller checks the request. If it is legal, it opens a bus cycle by pulling the address strobe low for one clock. It drives the direction line and four active-low byte enables, and holds them until the external side pulls ready low. It then returns the read data, right-justified, together with a one-clock done pulse.

Byte lanes are numbered big-endian. Lane 0 is data bits 31:24, lane 1 is 23:16, lane 2 is 15:8 and lane 3 is 7:0, and enable n selects lane n. On a 32-bit bus a write enables only the lanes it touches, while a read enables every lane. On the narrow buses the two upper enables carry the low address bits instead. A request that is misaligned, wider than the bus, or uses a reserved code is refused with a one-clock error pulse, and no bus cycle is started for it.

The state machine has three states. In ST_IDLE a legal request is accepted, which is transition T_ACCEPT, while an illegal one is refused and the machine stays put, which is T_REFUSE. ST_START is the strobe clock, and it always moves on to ST_WAIT by T_STROBE. In ST_WAIT ready is sampled. The machine holds there while ready stays high (T_HOLD) and returns to ST_IDLE when ready is low (T_END), raising done on that edge.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, bus_as_n and bus_rw_n are 1, bus_be_n is 4'b1111, bus_doe is 0, and rsp_done and rsp_err are 0.
- R2: A legal request seen with req_valid high in ST_IDLE gives bus_as_n = 0 for exactly the next clock (ST_START), followed by ST_WAIT. bus_rdy_n is ignored during ST_START.
- R3: bus_rdy_n sampled low in ST_WAIT ends the cycle. rsp_done is 1 for exactly the clock after that edge, and rsp_rdata is valid in that clock. The bus outputs then return to their R1 idle values.
- R4: bus_rw_n is 0 through a write cycle and 1 through a read cycle or idle. bus_rw_n, bus_be_n and bus_addr stay unchanged from ST_START to the end of the cycle.
- R5: For a 32-bit-bus write (bus_mode 2), bus_be_n[n] is the enable of lane n. A byte at offset k drives only bit k low, so offsets 0..3 give 1110, 1101, 1011, 0111. A halfword at offset 0 gives 1100, a halfword at offset 2 gives 0011, and a word gives 0000.
- R6: Any read on a 32-bit bus drives bus_be_n = 4'b0000, whatever the size.
- R7: On the 8-bit bus (bus_mode 0) and the 16-bit bus (bus_mode 1), bus_be_n[0] and bus_be_n[1] are 0, bus_be_n[2] equals address bit 1 and bus_be_n[3] equals address bit 0, for reads and writes.
- R8: Write data goes out on bus_dout with unused bits at zero, and bus_doe is 1 only during a write cycle. On the 32-bit bus a byte lands in lane k (offset k), a halfword at offset 0 in bits 31:16 and at offset 2 in bits 15:0, and a word fills all 32 bits. On the 16-bit bus a halfword uses bits 15:0, and a byte uses 15:8 at an even address or 7:0 at an odd one. On the 8-bit bus a byte uses bits 7:0.
- R9: Read data is taken from the same bit positions as R8 and returned on rsp_rdata, right-justified and zero-extended.
- R10: A halfword at an odd address, or a word at an address not a multiple of 4, is refused. rsp_err is 1 for the one clock after the request edge, and bus_as_n stays 1.
- R11: A request is refused in the same way as R10 in four cases: a word on the 8-bit or 16-bit bus, a halfword on the 8-bit bus, size code 3, or bus_mode 3. Size codes are 0 byte, 1 halfword, 2 word.
- R12: req_valid is ignored outside ST_IDLE. It starts no strobe and does not change bus_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present (sampled in ST_IDLE) |
| req_addr | input | AW | Request byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-justified |
| bus_mode | input | 2 | 0 8-bit, 1 16-bit, 2 32-bit bus |
| bus_addr | output | AW | Address of the current cycle |
| bus_as_n | output | 1 | Address strobe, low in the first clock |
| bus_rw_n | output | 1 | Low for write cycles |
| bus_be_n | output | 4 | Byte enables, bit n is lane n |
| bus_dout | output | 32 | Data driven toward the bus |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | 32 | Data returned from the bus |
| bus_rdy_n | input | 1 | Ready, low ends the cycle |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | One-clock refusal pulse |
| rsp_rdata | output | 32 | Read data, right-justified |

## Verification
The bench builds the controller with AW = 12. This shows that the address width is only carried through, and that lane choice, alignment and narrow-bus enables depend only on the two low address bits. At that width every address the bench uses stays readable in the failure messages. All three bus widths are driven from the one instance through bus_mode, so each lane position, each refusal case and the address-bit enables are all reached without rebuilding.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    localparam int DW    = 32;
    localparam int LANES = DW / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        BW_8    = 2'd0,
        BW_16   = 2'd1,
        BW_32   = 2'd2,
        BW_RSVD = 2'd3
    } width_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2
    } state_e;

endpackage

// File: rtl/ebc_req_check.sv
module ebc_req_check
    import ebc_pkg::*;
(
    input  size_e      size,
    input  width_e     mode,
    input  logic [1:0] off,
    output logic       refuse
);
    logic misaligned;
    logic too_wide;
    logic reserved;

    always_comb begin
        misaligned = ((size == SZ_HALF) && off[0]) ||
                     ((size == SZ_WORD) && (off != 2'b00));
        too_wide   = ((mode == BW_8)  && (size != SZ_BYTE)) ||
                     ((mode == BW_16) && (size == SZ_WORD));
        reserved   = (size == SZ_RSVD) || (mode == BW_RSVD);
        refuse     = misaligned || too_wide || reserved;
    end
endmodule

// File: rtl/ebc_lane_enable.sv
module ebc_lane_enable
    import ebc_pkg::*;
(
    input  logic             write,
    input  size_e            size,
    input  width_e           mode,
    input  logic [1:0]       off,
    output logic [LANES-1:0] be_n
);
    always_comb begin
        be_n = '0;
        if (mode != BW_32) begin
            be_n = {off[0], off[1], 2'b00};
        end else if (write) begin
            unique case (size)
                SZ_BYTE: be_n = ~(LANES'(1) << off);
                SZ_HALF: be_n = off[1] ? 4'b0011 : 4'b1100;
                default: be_n = '0;
            endcase
        end
    end
endmodule

// File: rtl/ebc_data_steer.sv
module ebc_data_steer
    import ebc_pkg::*;
(
    input  size_e          size,
    input  width_e         mode,
    input  logic [1:0]     off,
    input  logic [DW-1:0]  wdata,
    input  logic [DW-1:0]  din,
    output logic [DW-1:0]  dout,
    output logic [DW-1:0]  rdata
);
    localparam int SHW = $clog2(DW);

    logic [SHW-1:0] sh;
    logic [DW-1:0]  mask;

    always_comb begin
        unique case (size)
            SZ_BYTE: mask = DW'(8'hFF);
            SZ_HALF: mask = DW'(16'hFFFF);
            default: mask = '1;
        endcase
        sh = '0;
        if (mode == BW_32) begin
            if (size == SZ_BYTE)      sh = SHW'({~off, 3'b000});
            else if (size == SZ_HALF) sh = off[1] ? SHW'(0) : SHW'(16);
        end else if (mode == BW_16 && size == SZ_BYTE) begin
            sh = off[0] ? SHW'(0) : SHW'(8);
        end
        dout  = (wdata & mask) << sh;
        rdata = (din >> sh) & mask;
    end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_write,
    input  logic [31:0]   req_wdata,
    input  logic [1:0]    bus_mode,
    output logic [AW-1:0] bus_addr,
    output logic          bus_as_n,
    output logic          bus_rw_n,
    output logic [3:0]    bus_be_n,
    output logic [31:0]   bus_dout,
    output logic          bus_doe,
    input  logic [31:0]   bus_din,
    input  logic          bus_rdy_n,
    output logic          rsp_done,
    output logic          rsp_err,
    output logic [31:0]   rsp_rdata
);
    state_e          state, state_nx;
    logic            refuse;
    logic            accept;

    logic [AW-1:0]   lat_addr;
    size_e           lat_size;
    width_e          lat_mode;
    logic            lat_write;
    logic [DW-1:0]   lat_wdata;

    logic [LANES-1:0] lane_be_n;
    logic [DW-1:0]    steer_dout;
    logic [DW-1:0]    steer_rdata;

    ebc_req_check u_check (
        .size   (size_e'(req_size)),
        .mode   (width_e'(bus_mode)),
        .off    (req_addr[1:0]),
        .refuse (refuse)
    );

    ebc_lane_enable u_lane (
        .write (lat_write),
        .size  (lat_size),
        .mode  (lat_mode),
        .off   (lat_addr[1:0]),
        .be_n  (lane_be_n)
    );

    ebc_data_steer u_steer (
        .size  (lat_size),
        .mode  (lat_mode),
        .off   (lat_addr[1:0]),
        .wdata (lat_wdata),
        .din   (bus_din),
        .dout  (steer_dout),
        .rdata (steer_rdata)
    );

    assign accept = (state == ST_IDLE) && req_valid && !refuse;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept)     state_nx = ST_START;
            ST_START:                 state_nx = ST_WAIT;
            ST_WAIT:  if (!bus_rdy_n) state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_size  <= SZ_BYTE;
            lat_mode  <= BW_32;
            lat_write <= 1'b0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_size  <= size_e'(req_size);
            lat_mode  <= width_e'(bus_mode);
            lat_write <= req_write;
            lat_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= (state == ST_WAIT) && !bus_rdy_n;
            rsp_err  <= (state == ST_IDLE) && req_valid && refuse;
            if ((state == ST_WAIT) && !bus_rdy_n && !lat_write)
                rsp_rdata <= steer_rdata;
        end
    end

    always_comb begin
        bus_addr = lat_addr;
        bus_as_n = 1'b1;
        bus_rw_n = 1'b1;
        bus_be_n = '1;
        bus_dout = '0;
        bus_doe  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_START, ST_WAIT: begin
                bus_as_n = (state != ST_START);
                bus_rw_n = !lat_write;
                bus_be_n = lane_be_n;
                bus_doe  = lat_write;
                bus_dout = lat_write ? steer_dout : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker
    import ebc_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input state_e        st,
    input logic [AW-1:0] bus_addr,
    input logic          bus_as_n,
    input logic          bus_rw_n,
    input logic [3:0]    bus_be_n,
    input logic          bus_doe,
    input logic          bus_rdy_n,
    input logic          rsp_done,
    input logic          rsp_err
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (bus_as_n && bus_rw_n && bus_be_n == 4'hF && !bus_doe)); // R1
    AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as_n |=> bus_as_n); // R2
    AST_STROBE_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START) |=> (st == ST_WAIT)); // R2
    AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(st == ST_WAIT && !bus_rdy_n)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R3
    AST_CYCLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> ($stable(bus_rw_n) && $stable(bus_be_n) && $stable(bus_addr))); // R4
    AST_READ_LOW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && bus_rw_n) |-> (bus_be_n[1:0] == 2'b00)); // R6
    AST_REFUSE_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (st == ST_IDLE && bus_as_n)); // R10
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !rsp_done); // R11
endmodule

bind ext_bus_ctrl ebc_checker #(.AW(AW)) u_ebc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (state),
    .bus_addr  (bus_addr),
    .bus_as_n  (bus_as_n),
    .bus_rw_n  (bus_rw_n),
    .bus_be_n  (bus_be_n),
    .bus_doe   (bus_doe),
    .bus_rdy_n (bus_rdy_n),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err)
);

// File: tb/tb_ext_bus_ctrl.sv
module tb_ext_bus_ctrl;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic [1:0]    bus_mode = 2'd2;
    logic [AW-1:0] bus_addr;
    logic          bus_as_n, bus_rw_n, bus_doe;
    logic [3:0]    bus_be_n;
    logic [31:0]   bus_dout;
    logic [31:0]   bus_din = '0;
    logic          bus_rdy_n = 1'b1;
    logic          rsp_done, rsp_err;
    logic [31:0]   rsp_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ext_bus_ctrl #(.AW(AW)) dut (.*);

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // One legal bus cycle; waits >= 1 clocks spent in ST_WAIT before ready.
    task automatic run_cycle(string req, logic wr, logic [1:0] sz, logic [1:0] md,
                             logic [AW-1:0] a, logic [31:0] wd, logic [31:0] din,
                             int waits, logic [3:0] exp_be, logic [31:0] exp_dout,
                             logic [31:0] exp_rd);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_size = sz; bus_mode = md;
        req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 0; bus_din = din;
        bus_rdy_n = 0; // ignored in ST_START (R2)
        chk("R2", "strobe low", 32'(bus_as_n), 0);
        chk("R4", "rw_n", 32'(bus_rw_n), 32'(!wr));
        chk(req, "be_n", 32'(bus_be_n), 32'(exp_be));
        chk("R4", "addr", 32'(bus_addr), 32'(a));
        chk("R8", "doe", 32'(bus_doe), 32'(wr));
        if (wr) chk(req, "dout", bus_dout, exp_dout);
        @(negedge clk);
        bus_rdy_n = 1;
        for (int i = 0; i < waits; i++) begin
            if (i > 0) @(negedge clk);
            chk("R2", "strobe high in wait", 32'(bus_as_n), 1);
            chk("R3", "no early done", 32'(rsp_done), 0);
            chk("R4", "be held", 32'(bus_be_n), 32'(exp_be));
            chk("R4", "rw held", 32'(bus_rw_n), 32'(!wr));
        end
        bus_rdy_n = 0;
        @(negedge clk);
        bus_rdy_n = 1;
        chk("R3", "done", 32'(rsp_done), 1);
        if (!wr) chk(req, "rdata", rsp_rdata, exp_rd);
        chk("R3", "idle outputs", {bus_as_n, bus_rw_n, bus_be_n, bus_doe}, 7'b1111110);
        @(negedge clk);
        chk("R3", "done one clock", 32'(rsp_done), 0);
    endtask

    task automatic refuse(string req, logic [1:0] sz, logic [1:0] md, logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_size = sz; bus_mode = md; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk(req, "err", 32'(rsp_err), 1);
        chk(req, "no strobe", 32'(bus_as_n), 1);
        @(negedge clk);
        chk(req, "err one clock", 32'(rsp_err), 0);
        chk(req, "still no strobe", 32'(bus_as_n), 1);
    endtask

    task automatic test_reset();
        chk("R1", "as_n", 32'(bus_as_n), 1);
        chk("R1", "rw_n", 32'(bus_rw_n), 1);
        chk("R1", "be_n", 32'(bus_be_n), 4'hF);
        chk("R1", "done/err/doe", {rsp_done, rsp_err, bus_doe}, 0);
    endtask

    task automatic test_busy_ignore();
        @(negedge clk);
        req_valid = 1; req_write = 0; req_size = 2; bus_mode = 2; req_addr = 12'h100;
        @(negedge clk);
        req_addr = 12'h204; // req_valid kept high while busy
        @(negedge clk);
        chk("R12", "no second strobe", 32'(bus_as_n), 1);
        chk("R12", "addr kept", 32'(bus_addr), 32'h100);
        @(negedge clk);
        chk("R12", "addr kept later", 32'(bus_addr), 32'h100);
        req_valid = 0; bus_din = 32'hCAFE0001; bus_rdy_n = 0;
        @(negedge clk);
        bus_rdy_n = 1;
        chk("R12", "first cycle done", 32'(rsp_done), 1);
        chk("R9", "word read", rsp_rdata, 32'hCAFE0001);
        @(negedge clk);
        chk("R12", "idle after", 32'(bus_as_n), 1);
    endtask

    initial begin
        #1;
        test_reset();
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1;
        @(negedge clk);
        test_reset();

        // 32-bit writes: enables and lanes (R5, R8)
        run_cycle("R5", 1, 0, 2, 12'h010, 32'h000000A5, 0, 1, 4'b1110, 32'hA5000000, 0);
        run_cycle("R5", 1, 0, 2, 12'h011, 32'h000000A5, 0, 2, 4'b1101, 32'h00A50000, 0);
        run_cycle("R8", 1, 0, 2, 12'h012, 32'hFFFFFFA5, 0, 1, 4'b1011, 32'h0000A500, 0);
        run_cycle("R5", 1, 0, 2, 12'h013, 32'h000000A5, 0, 1, 4'b0111, 32'h000000A5, 0);
        run_cycle("R5", 1, 1, 2, 12'h020, 32'h00001234, 0, 3, 4'b1100, 32'h12340000, 0);
        run_cycle("R8", 1, 1, 2, 12'h022, 32'hFFFF1234, 0, 1, 4'b0011, 32'h00001234, 0);
        run_cycle("R5", 1, 2, 2, 12'h024, 32'hDEADBEEF, 0, 1, 4'b0000, 32'hDEADBEEF, 0);

        // 32-bit reads (R6, R9)
        run_cycle("R6", 0, 0, 2, 12'h031, 0, 32'h11223344, 1, 4'b0000, 0, 32'h00000022);
        run_cycle("R9", 0, 0, 2, 12'h033, 0, 32'h11223344, 1, 4'b0000, 0, 32'h00000044);
        run_cycle("R9", 0, 1, 2, 12'h032, 0, 32'h11223344, 2, 4'b0000, 0, 32'h00003344);
        run_cycle("R6", 0, 1, 2, 12'h030, 0, 32'h11223344, 1, 4'b0000, 0, 32'h00001122);

        // narrow buses (R7, R8, R9)
        run_cycle("R7", 0, 0, 1, 12'h043, 0, 32'hAAAA5566, 1, 4'b1100, 0, 32'h00000066);
        run_cycle("R9", 0, 0, 1, 12'h042, 0, 32'hAAAA5566, 1, 4'b0100, 0, 32'h00000055);
        run_cycle("R7", 1, 1, 1, 12'h042, 32'h0000BEEF, 0, 1, 4'b0100, 32'h0000BEEF, 0);
        run_cycle("R8", 1, 0, 1, 12'h040, 32'h0000005A, 0, 1, 4'b0000, 32'h00005A00, 0);
        run_cycle("R7", 1, 0, 0, 12'h051, 32'h0000005A, 0, 1, 4'b1000, 32'h0000005A, 0);
        run_cycle("R9", 0, 0, 0, 12'h052, 0, 32'hAAAA5566, 1, 4'b0100, 0, 32'h00000066);

        // refusals (R10, R11)
        refuse("R10", 1, 2, 12'h061);
        refuse("R10", 2, 2, 12'h062);
        refuse("R11", 2, 1, 12'h060);
        refuse("R11", 1, 0, 12'h060);
        refuse("R11", 3, 2, 12'h060);
        refuse("R11", 0, 3, 12'h060);

        test_busy_ignore();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule